// File: doc/BRIEF.md
# Command Response Error and Timeout Monitor

This block sits beside the command engine of an SD/MMC host controller and supervises the card's reply to each command. When a command that expects a reply finishes going out on the line, the block starts counting serial clock ticks. If the reply's start strobe does not arrive within a fixed number of ticks, it declares a response timeout.

When the reply word is complete, the block keeps a copy of it for software. For commands marked as returning the 32-bit card status (R1), it also compares that word with a programmable reference under a programmable mask, and any enabled bit that differs is a response error.

Either fault sets a sticky flag and raises a one-cycle interrupt pulse. Either fault also asserts a halt output that stops DMA requests and data transfer to the card. The halt holds until software issues a clear pulse, which also re-arms the monitor.

Top module: `resp_watch`

## Requirements
- R1: After reset both flags, both interrupts and the halt output are low, and the held response reads 0.
- R2: After a command completes with `expectResp`=1, `toFlag` stays low through 63 `sclkTick` pulses with no `respStart`, and it rises on the 64th pulse (TIMEOUT_TICKS=64).
- R3: The timeout count advances only in cycles where `sclkTick` is high. Cycles without a tick, however many, do not count.
- R4: A `respStart` seen before the 64th tick ends the wait, so no timeout follows however many ticks come after it.
- R5: A command completed with `expectResp`=0 never produces a timeout.
- R6: For a command completed with `isR1`=1, the response word delivered with `respValid` sets `errFlag` exactly when ((respWord XOR statusRef) AND statusMask) is nonzero. A mask bit of 1 enables that bit.
- R7: For a command completed with `isR1`=0, no mask check is made and `errFlag` stays low whatever the word.
- R8: `lastResp` takes the word presented with `respValid` after an awaited response starts, and holds it otherwise.
- R9: Each interrupt is a single-cycle pulse in the cycle its flag rises. The flags stay high until cleared.
- R10: `haltDma` is high whenever either flag is set, and it stays high across later commands until cleared.
- R11: A `swClear` pulse clears both flags and the halt output, abandons any pending wait, and takes priority over every other input in that cycle.
- R12: A `cmdStart` abandons any pending wait, and the next command's count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkTick | input | 1 | One-cycle enable per serial clock period |
| cmdStart | input | 1 | A new command begins sending |
| cmdDone | input | 1 | The command finished sending |
| expectResp | input | 1 | Qualifier at cmdDone: a response is expected |
| isR1 | input | 1 | Qualifier at cmdDone: the response carries card status |
| respStart | input | 1 | Response start bit detected |
| respValid | input | 1 | Full response word available on respWord |
| respWord | input | 32 | Received response word |
| statusMask | input | 32 | Enable mask for the status comparison |
| statusRef | input | 32 | Reference (expected) status value |
| swClear | input | 1 | Software clear and re-arm pulse |
| errFlag | output | 1 | Sticky response-error flag |
| toFlag | output | 1 | Sticky response-timeout flag |
| errIrq | output | 1 | Response-error interrupt pulse |
| toIrq | output | 1 | Response-timeout interrupt pulse |
| haltDma | output | 1 | Stop DMA requests and card data transfer |
| lastResp | output | 32 | Copy of the most recent response word |

## Verification
An off-by-one in the tick counter would move the timeout flag to the 63rd or 65th tick, so the bench checks the flag after every single tick. A counter that also advanced on idle cycles would fire early, and idle gaps between ticks expose this. A wrong mask polarity or a missing XOR would show in the error flag at the edge after the word arrives, so the bench sweeps every bit position with its mask bit both enabled and disabled. A sticky flag that was lost, or a pulse that stuck, would show on the first cycle after the event, or across later commands.

// File: rtl/resp_watch_pkg.sv
package resp_watch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_HEAD = 2'd1,
    ST_WAIT_WORD = 2'd2
  } watchState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/resp_watch_dp.sv
module resp_watch_dp
  import resp_watch_pkg::*;
#(
  parameter int RESP_W        = 32,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [RESP_W-1:0] respWord,
  input  logic [RESP_W-1:0] statusMask,
  input  logic [RESP_W-1:0] statusRef,
  output logic              cntHit,
  output logic              mismatch,
  output logic [RESP_W-1:0] lastResp
);

  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.cntClr) begin
      tickCnt <= '0;
    end else if (strobe.cntInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastResp <= '0;
    end else if (strobe.capture) begin
      lastResp <= respWord;
    end
  end

  assign cntHit   = (tickCnt == LAST_CNT);
  assign mismatch = |((respWord ^ statusRef) & statusMask);

endmodule

// File: rtl/resp_watch_ctrl.sv
module resp_watch_ctrl
  import resp_watch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkTick,
  input  logic      cmdStart,
  input  logic      cmdDone,
  input  logic      expectResp,
  input  logic      isR1,
  input  logic      respStart,
  input  logic      respValid,
  input  logic      swClear,
  input  logic      cntHit,
  input  logic      mismatch,
  output dpStrobe_t strobe,
  output logic      errFlag,
  output logic      toFlag,
  output logic      errIrq,
  output logic      toIrq
);

  watchState_t state;
  logic        r1Pending;
  logic        override;
  logic        expire;
  logic        statusBad;

  assign override  = swClear | cmdStart | cmdDone;
  assign expire    = !override && (state == ST_WAIT_HEAD) && !respStart
                     && sclkTick && cntHit;
  assign statusBad = !override && (state == ST_WAIT_WORD) && respValid
                     && r1Pending && mismatch;

  always_comb begin
    strobe.cntClr  = override;
    strobe.cntInc  = !override && (state == ST_WAIT_HEAD) && !respStart
                     && sclkTick && !cntHit;
    strobe.capture = !override && (state == ST_WAIT_WORD) && respValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      r1Pending <= 1'b0;
      errFlag   <= 1'b0;
      toFlag    <= 1'b0;
      errIrq    <= 1'b0;
      toIrq     <= 1'b0;
    end else if (swClear) begin
      state     <= ST_IDLE;
      r1Pending <= 1'b0;
      errFlag   <= 1'b0;
      toFlag    <= 1'b0;
      errIrq    <= 1'b0;
      toIrq     <= 1'b0;
    end else begin
      errIrq <= statusBad & ~errFlag;
      toIrq  <= expire & ~toFlag;
      if (statusBad) errFlag <= 1'b1;
      if (expire)    toFlag  <= 1'b1;
      if (cmdStart) begin
        state <= ST_IDLE;
      end else if (cmdDone) begin
        state     <= expectResp ? ST_WAIT_HEAD : ST_IDLE;
        r1Pending <= isR1;
      end else begin
        unique case (state)
          ST_WAIT_HEAD: begin
            if (respStart)   state <= ST_WAIT_WORD;
            else if (expire) state <= ST_IDLE;
          end
          ST_WAIT_WORD: if (respValid) state <= ST_IDLE;
          default:      state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/resp_watch.sv
module resp_watch
  import resp_watch_pkg::*;
#(
  parameter int RESP_W        = 32,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkTick,
  input  logic              cmdStart,
  input  logic              cmdDone,
  input  logic              expectResp,
  input  logic              isR1,
  input  logic              respStart,
  input  logic              respValid,
  input  logic [RESP_W-1:0] respWord,
  input  logic [RESP_W-1:0] statusMask,
  input  logic [RESP_W-1:0] statusRef,
  input  logic              swClear,
  output logic              errFlag,
  output logic              toFlag,
  output logic              errIrq,
  output logic              toIrq,
  output logic              haltDma,
  output logic [RESP_W-1:0] lastResp
);

  dpStrobe_t strobe;
  logic      cntHit;
  logic      mismatch;

  resp_watch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkTick(sclkTick), .cmdStart(cmdStart),
    .cmdDone(cmdDone), .expectResp(expectResp), .isR1(isR1),
    .respStart(respStart), .respValid(respValid), .swClear(swClear),
    .cntHit(cntHit), .mismatch(mismatch), .strobe(strobe),
    .errFlag(errFlag), .toFlag(toFlag), .errIrq(errIrq), .toIrq(toIrq)
  );

  resp_watch_dp #(.RESP_W(RESP_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .respWord(respWord),
    .statusMask(statusMask), .statusRef(statusRef), .cntHit(cntHit),
    .mismatch(mismatch), .lastResp(lastResp)
  );

  assign haltDma = errFlag | toFlag;

endmodule

// File: rtl/resp_watch_chk.sv
module resp_watch_chk #(
  parameter int RESP_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclkTick,
  input logic              respValid,
  input logic              swClear,
  input logic              errFlag,
  input logic              toFlag,
  input logic              errIrq,
  input logic              toIrq,
  input logic              haltDma,
  input logic [RESP_W-1:0] lastResp
);

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> !errIrq);
  p_to_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    toIrq |=> !toIrq);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !swClear) |=> errFlag);
  p_to_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !swClear) |=> toFlag);
  p_irq_with_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq |-> errFlag) and (toIrq |-> toFlag));
  p_halt_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltDma) |-> (errIrq || toIrq));
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    swClear |=> (!errFlag && !toFlag && !haltDma));
  p_to_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(sclkTick));
  p_hold_resp_r8: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |=> $stable(lastResp));

endmodule

bind resp_watch resp_watch_chk #(.RESP_W(RESP_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclkTick(sclkTick), .respValid(respValid),
  .swClear(swClear), .errFlag(errFlag), .toFlag(toFlag), .errIrq(errIrq),
  .toIrq(toIrq), .haltDma(haltDma), .lastResp(lastResp)
);

// File: tb/tb_resp_watch.sv
`timescale 1ns/1ps
module tb_resp_watch;

  localparam int LIMIT = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkTick = 0, cmdStart = 0, cmdDone = 0, expectResp = 0, isR1 = 0;
  logic        respStart = 0, respValid = 0, swClear = 0;
  logic [31:0] respWord = '0, statusMask = '0, statusRef = '0;
  logic        errFlag, toFlag, errIrq, toIrq, haltDma;
  logic [31:0] lastResp;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  resp_watch dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearSw();
    @(negedge clk) swClear = 1;
    @(negedge clk) swClear = 0;
  endtask

  task automatic issueCmd(input logic exp, input logic r1);
    @(negedge clk) cmdStart = 1;
    @(negedge clk) cmdStart = 0; cmdDone = 1; expectResp = exp; isR1 = r1;
    @(negedge clk) cmdDone = 0; expectResp = 0; isR1 = 0;
  endtask

  // gap idle cycles, then one tick; returns at the negedge after its capture
  task automatic tick(input int gap);
    repeat (gap) @(negedge clk);
    sclkTick = 1;
    @(negedge clk) sclkTick = 0;
  endtask

  task automatic respond(input logic [31:0] w);
    respStart = 1;
    @(negedge clk) respStart = 0; respValid = 1; respWord = w;
    @(negedge clk) respValid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 errFlag", {31'b0, errFlag}, 0);
    check("R1 toFlag", {31'b0, toFlag}, 0);
    check("R1 irqs", {30'b0, errIrq, toIrq}, 0);
    check("R1 haltDma", {31'b0, haltDma}, 0);
    check("R1 lastResp", lastResp, 0);
    rstN = 1;
    @(negedge clk);

    // R2 / R9: flag and pulse checked after every tick
    issueCmd(1, 0);
    for (int i = 1; i <= LIMIT + 3; i++) begin
      tick(0);
      check("R2 toFlag per tick", {31'b0, toFlag}, (i >= LIMIT) ? 1 : 0);
      check("R9 toIrq per tick", {31'b0, toIrq}, (i == LIMIT) ? 1 : 0);
    end
    check("R10 halt on timeout", {31'b0, haltDma}, 1);
    issueCmd(1, 1);
    respond(32'h0);
    check("R10 halt held across command", {31'b0, haltDma}, 1);
    check("R9 toFlag sticky", {31'b0, toFlag}, 1);
    clearSw();
    check("R11 clear flags", {30'b0, errFlag, toFlag}, 0);
    check("R11 clear halt", {31'b0, haltDma}, 0);

    // R3 idle gaps do not count
    issueCmd(1, 0);
    for (int i = 1; i < LIMIT; i++) tick(i % 4);
    repeat (20) @(negedge clk);
    check("R3 no timeout after gaps", {31'b0, toFlag}, 0);
    tick(3);
    check("R3 timeout on last tick", {31'b0, toFlag}, 1);
    clearSw();

    // R4 response start ends wait
    issueCmd(1, 0);
    for (int i = 1; i < LIMIT; i++) tick(0);
    respond(32'hCAFE_0001);
    for (int i = 0; i < 10; i++) tick(0);
    check("R4 no timeout after start", {31'b0, toFlag}, 0);
    check("R8 lastResp captured", lastResp, 32'hCAFE_0001);

    // R5 no response expected
    issueCmd(0, 0);
    for (int i = 0; i < LIMIT + 6; i++) tick(0);
    check("R5 no timeout", {31'b0, toFlag}, 0);

    // R12 new command restarts count
    issueCmd(1, 0);
    for (int i = 0; i < 40; i++) tick(0);
    issueCmd(1, 0);
    for (int i = 0; i < LIMIT - 1; i++) tick(0);
    check("R12 restart no early timeout", {31'b0, toFlag}, 0);
    tick(0);
    check("R12 timeout from restart", {31'b0, toFlag}, 1);

    // R11 clear abandons pending wait
    clearSw();
    issueCmd(1, 0);
    for (int i = 0; i < 40; i++) tick(0);
    clearSw();
    for (int i = 0; i < 40; i++) tick(0);
    check("R11 wait abandoned", {31'b0, toFlag}, 0);

    // R6 exhaustive single-bit sweep, mask bit enabled and disabled
    statusRef = 32'h0000_0900;
    for (int b = 0; b < 32; b++) begin
      for (int en = 0; en < 2; en++) begin
        logic [31:0] w;
        statusMask = (en != 0) ? 32'hFFFF_FFFF : ~(32'h1 << b);
        w = statusRef ^ (32'h1 << b);
        issueCmd(1, 1);
        tick(0);
        respond(w);
        check("R6 errFlag bit sweep", {31'b0, errFlag}, en[0]);
        check("R9 errIrq pulse", {31'b0, errIrq}, en[0]);
        check("R8 lastResp sweep", lastResp, w);
        @(negedge clk);
        check("R9 errIrq single", {31'b0, errIrq}, 0);
        clearSw();
      end
    end

    // R6 multi-bit patterns, expected value computed arithmetically
    for (int k = 0; k < 24; k++) begin
      logic [31:0] w;
      logic        expErr;
      statusMask = 32'h9E37_79B9 * (k + 1);
      statusRef  = 32'h7F4A_7C15 ^ (k * 32'h0101_0101);
      w = statusRef ^ ((32'h1 << (k % 32)) | (32'h8000_0000 >> (k % 7)));
      expErr = ((w ^ statusRef) & statusMask) != 0;
      issueCmd(1, 1);
      respond(w);
      check("R6 errFlag pattern", {31'b0, errFlag}, {31'b0, expErr});
      check("R10 halt follows error", {31'b0, haltDma}, {31'b0, expErr});
      clearSw();
    end

    // R7 non-R1 response not checked
    statusMask = 32'hFFFF_FFFF;
    statusRef  = 32'h0;
    issueCmd(1, 0);
    respond(32'hFFFF_FFFF);
    check("R7 no error for non-R1", {31'b0, errFlag}, 0);
    check("R8 lastResp non-R1", lastResp, 32'hFFFF_FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule